// File: doc/BRIEF.md
# Serial MSB-First Magnitude Comparator

This block compares two unsigned numbers of `W` bits that reach it as two synchronous serial streams, one bit of each operand per accepted clock, most significant bit first. For every bit it forms the exclusive-OR of the two operand bits and keeps the exclusive-OR results of the frame so far in a short delay line. A bit position is flagged as the leading mismatch when its own exclusive-OR is one and every delayed copy is zero. At that position the operand bits decide the polarity, and a single-cycle pulse appears on the greater-than or the less-than output.

Each result is therefore a pulse stream one frame long: all zero when its relation is false, and holding exactly one high cycle when it is true. The equal output pulses once, after the last bit, when no mismatch was seen. After the last bit a guard interval of `W` cycles lets the delay line drain back to zero. Inputs are ignored during that interval. A frame start offered there raises an error pulse and is dropped.

A frame opens on a cycle in which `frame_start` and `bit_valid` are both high. Later bits of the frame are taken on cycles with `bit_valid` high. Cycles with `bit_valid` low are stalls and do not count.

Top module: `serial_mag_cmp`

## Requirements
- R1: A frame is exactly W accepted bits. Its first bit is taken when frame_start and bit_valid are both high in the idle state. Each later bit is taken on a cycle with bit_valid high. Cycles with bit_valid low inside a frame change nothing and raise no output.
- R2: When the first differing bit position (counted from the MSB) has a_bit=1 and b_bit=0, a_gt_b is high for exactly the one cycle that follows the clock edge taking that bit.
- R3: When the first differing bit position has a_bit=0 and b_bit=1, a_lt_b is high for exactly the one cycle that follows the clock edge taking that bit.
- R4: Per frame, at most one of a_gt_b, a_lt_b and a_eq_b pulses, and it pulses only once. Later differing bits produce no further pulse.
- R5: When all W bit pairs of a frame are equal, a_eq_b is high for the one cycle that follows the edge taking the last bit. It stays low otherwise.
- R6: After the last bit of a frame, the next W cycles form a guard interval. In it, a_bit, b_bit and bit_valid have no effect on any output. A frame can start on the cycle right after the guard interval.
- R7: frame_start with bit_valid high outside the idle state raises start_err for one cycle on the following cycle. Inside the guard interval the start is dropped. Inside a running frame the bit is still taken as a data bit of that frame.
- R8: In the idle state, bit_valid without frame_start is ignored, and no output pulses.
- R9: While rst_n is low, and in the first cycle after its release, all outputs are low.
- R10: The exclusive-OR history is empty whenever the block is idle, so a frame's result never depends on an earlier frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Bit pair present this cycle |
| frame_start | input | 1 | Marks the first (MSB) bit pair of a frame |
| a_bit | input | 1 | Serial bit of operand A |
| b_bit | input | 1 | Serial bit of operand B |
| a_gt_b | output | 1 | Pulse at the leading mismatch when A > B |
| a_lt_b | output | 1 | Pulse at the leading mismatch when A < B |
| a_eq_b | output | 1 | Pulse after the last bit when A = B |
| start_err | output | 1 | Pulse when a frame start arrives outside idle |

## Verification
The assertions assume that the bit inputs are settled at each rising edge and that a frame is made of whole accepted bits. They do not assume that a stream respects the guard interval. Instead they check that a start offered in a busy state only raises the error pulse, and that the history has drained whenever the sequencer is idle. The stimulus drives inputs on the falling edge and fills stalls and guard cycles with random bit values. It places frame starts in the guard interval and in the middle of a frame on purpose, so that the ignore and error paths run under the same checks as normal frames.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_GUARD = 2'd2
  } seq_st_t;

  // A bit position leads the mismatch when it differs and no earlier one did.
  function automatic logic lead_diff(input logic differs, input logic any_prior);
    return differs & ~any_prior;
  endfunction

  // Polarity of a leading mismatch: the operand holding the one is larger.
  function automatic logic [1:0] polarity(input logic hit, input logic a, input logic b);
    return {hit & a & ~b, hit & b & ~a};
  endfunction

  // Equality holds at the last bit when no mismatch was flagged in the frame.
  function automatic logic frame_equal(input logic last, input logic seen, input logic hit);
    return last & ~seen & ~hit;
  endfunction

endpackage

// File: rtl/frame_seq.sv
module frame_seq
  import smc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic frame_start,
  output logic take,
  output logic first,
  output logic last,
  output logic in_guard,
  output logic in_idle,
  output logic late_start
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  seq_st_t         st;
  logic [CW-1:0]   cnt;

  always_comb begin
    in_idle    = (st == ST_IDLE);
    in_guard   = (st == ST_GUARD);
    first      = in_idle & bit_valid & frame_start;
    take       = first | ((st == ST_RUN) & bit_valid);
    last       = (st == ST_RUN) & bit_valid & (cnt == LAST_IDX);
    late_start = bit_valid & frame_start & ~in_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (first) begin
            st  <= ST_RUN;
            cnt <= CW'(1);
          end
        end
        ST_RUN: begin
          if (bit_valid) begin
            if (cnt == LAST_IDX) begin
              st  <= ST_GUARD;
              cnt <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_GUARD: begin
          if (cnt == LAST_IDX) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          st  <= ST_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  // R6
  guard_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_IDLE) |-> $past(st == ST_GUARD));

  // R1
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (cnt != '0) && (cnt <= LAST_IDX));

endmodule

// File: rtl/xor_hist.sv
module xor_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         first,
  input  logic         in_guard,
  input  logic         in_idle,
  input  logic         x,
  output logic [W-2:0] prior
);

  localparam int HW = W - 1;

  logic [HW-1:0] hist;
  logic          sh_en;
  logic          sh_in;

  always_comb begin
    sh_en = take | in_guard;
    sh_in = take & x;
  end

  // Delayed lines 2..W; a fresh frame sees none of the old history.
  genvar k;
  generate
    for (k = 0; k < HW; k++) begin : g_line
      assign prior[k] = first ? 1'b0 : hist[k];
    end
  endgenerate

  generate
    for (k = 0; k < HW; k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      hist[0] <= 1'b0;
          else if (sh_en)  hist[0] <= sh_in;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      hist[k] <= 1'b0;
          else if (sh_en)  hist[k] <= first ? 1'b0 : hist[k-1];
        end
      end
    end
  endgenerate

  // R10
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (hist == '0));

endmodule

// File: rtl/first_diff_dec.sv
module first_diff_dec
  import smc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         first,
  input  logic         last,
  input  logic         a,
  input  logic         b,
  input  logic [W-2:0] prior,
  output logic         hit,
  output logic         gt_d,
  output logic         lt_d,
  output logic         eq_d
);

  logic seen;
  logic any_prior;

  always_comb begin
    any_prior    = |prior;
    hit          = take & lead_diff(a ^ b, any_prior);
    {gt_d, lt_d} = polarity(hit, a, b);
    eq_d         = frame_equal(last, seen, hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= 1'b0;
    else if (take)  seen <= first ? hit : (seen | hit);
  end

  // R4
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !first) |-> !seen);

endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
  import smc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic frame_start,
  input  logic a_bit,
  input  logic b_bit,
  output logic a_gt_b,
  output logic a_lt_b,
  output logic a_eq_b,
  output logic start_err
);

  logic         take, first, last, in_guard, in_idle, late_start;
  logic [W-2:0] prior;
  logic         hit, gt_d, lt_d, eq_d;

  frame_seq #(.W(W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .frame_start(frame_start),
    .take       (take),
    .first      (first),
    .last       (last),
    .in_guard   (in_guard),
    .in_idle    (in_idle),
    .late_start (late_start)
  );

  xor_hist #(.W(W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .first   (first),
    .in_guard(in_guard),
    .in_idle (in_idle),
    .x       (a_bit ^ b_bit),
    .prior   (prior)
  );

  first_diff_dec #(.W(W)) u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .take (take),
    .first(first),
    .last (last),
    .a    (a_bit),
    .b    (b_bit),
    .prior(prior),
    .hit  (hit),
    .gt_d (gt_d),
    .lt_d (lt_d),
    .eq_d (eq_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_gt_b    <= 1'b0;
      a_lt_b    <= 1'b0;
      a_eq_b    <= 1'b0;
      start_err <= 1'b0;
    end else begin
      a_gt_b    <= gt_d;
      a_lt_b    <= lt_d;
      a_eq_b    <= eq_d;
      start_err <= late_start;
    end
  end

  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_gt_b, a_lt_b, a_eq_b}));

  // R2
  gt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_gt_b |-> $past(take && a_bit && !b_bit));

  // R3
  lt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_lt_b |-> $past(take && b_bit && !a_bit));

  // R5
  eq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_eq_b |-> $past(last && (a_bit == b_bit)));

  // R7
  err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> $past(!in_idle && frame_start && bit_valid));

  // R6
  guard_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_guard |=> !(a_gt_b || a_lt_b || a_eq_b));

endmodule

// File: tb/sim_serial_mag_cmp.sv
`timescale 1ns/1ps
module sim_serial_mag_cmp;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic frame_start = 1'b0;
  logic a_bit = 1'b0;
  logic b_bit = 1'b0;
  logic a_gt_b, a_lt_b, a_eq_b, start_err;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  serial_mag_cmp #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .frame_start(frame_start),
    .a_bit(a_bit), .b_bit(b_bit),
    .a_gt_b(a_gt_b), .a_lt_b(a_lt_b), .a_eq_b(a_eq_b), .start_err(start_err)
  );

  // Index from the MSB of the leading differing bit, or -1 when the values match.
  function automatic int lead_pos(input logic [W-1:0] x, input logic [W-1:0] y);
    for (int i = 0; i < W; i++) begin
      if (x[W-1-i] != y[W-1-i]) return i;
    end
    return -1;
  endfunction

  function automatic string tag_of(input logic eg, input logic el, input logic ee, input logic er);
    if (eg) return "R2";
    if (el) return "R3";
    if (ee) return "R5";
    if (er) return "R7";
    return "R4";
  endfunction

  task automatic check(input logic eg, input logic el, input logic ee, input logic er, input string tag);
    n_chk++;
    if ({a_gt_b, a_lt_b, a_eq_b, start_err} !== {eg, el, ee, er}) begin
      n_bad++;
      $display("FAIL %s gt,lt,eq,err got %b%b%b%b expected %b%b%b%b at %0t",
               tag, a_gt_b, a_lt_b, a_eq_b, start_err, eg, el, ee, er, $time);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, check on the next falling edge.
  task automatic step(input logic v, input logic fs, input logic a, input logic b,
                      input logic eg, input logic el, input logic ee, input logic er,
                      input string tag);
    bit_valid = v; frame_start = fs; a_bit = a; b_bit = b;
    @(posedge clk);
    @(negedge clk);
    check(eg, el, ee, er, tag);
  endtask

  // R6: guard interval, random junk; err_at >= 0 places a start there (R7).
  task automatic guard(input int err_at);
    for (int g = 0; g < W; g++) begin
      logic v;
      v = (g == err_at) ? 1'b1 : 1'($urandom_range(0, 1));
      step(v, g == err_at, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'b0, 1'b0, 1'b0, g == err_at, (g == err_at) ? "R7" : "R6");
    end
  endtask

  task automatic send_frame(input logic [W-1:0] x, input logic [W-1:0] y,
                            input int stall_pct, input int late_at, input int err_at);
    int p;
    p = lead_pos(x, y);
    for (int i = 0; i < W; i++) begin
      logic eg, el, ee, er, fs;
      if (i > 0) begin
        while (int'($urandom_range(0, 99)) < stall_pct) begin
          // R1: stall cycle, nothing taken
          step(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'b0, 1'b0, 1'b0, 1'b0, "R1");
        end
      end
      fs = (i == 0) || (i == late_at);
      eg = (i == p) && x[W-1-i];
      el = (i == p) && y[W-1-i];
      ee = (i == W-1) && (p < 0);
      er = (i == late_at) && (i != 0);
      step(1'b1, fs, x[W-1-i], y[W-1-i], eg, el, ee, er, tag_of(eg, el, ee, er));
    end
    guard(err_at);
  endtask

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    check(1'b0, 1'b0, 1'b0, 1'b0, "R9");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, 1'b0, 1'b0, "R9");

    // R8: valid bits with no start while idle
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");

    // Directed corners
    send_frame('0, '0, 0, -1, -1);                       // R5 all zero
    send_frame('1, '1, 0, -1, -1);                       // R5 all one
    send_frame(W'(1), '0, 0, -1, -1);                    // R2 LSB only
    send_frame('0, W'(1), 0, -1, -1);                    // R3 LSB only
    send_frame({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 0, -1, -1); // R2 MSB then R4 later diffs
    send_frame({1'b0, {(W-1){1'b1}}}, {1'b1, {(W-1){1'b0}}}, 30, -1, -1); // R3 with stalls R1
    send_frame(W'(8'h5A), W'(8'h5A), 0, -1, 0);          // R7 start at guard head, dropped
    send_frame(W'(8'h5B), W'(8'h5A), 0, -1, W-1);        // R7 start at guard tail
    send_frame(W'(8'h33), W'(8'h31), 0, 3, -1);          // R7 start mid-frame, bit kept
    send_frame(W'(8'h31), W'(8'h33), 0, -1, -1);         // R10 fresh history

    // Random frames
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      case ($urandom_range(0, 3))
        0: y = x;
        1: y = x ^ W'(1 << $urandom_range(0, W-1));
        default: y = W'($urandom);
      endcase
      send_frame(x, y, (n % 3 == 0) ? 25 : 0, -1, (n % 17 == 0) ? int'($urandom_range(0, W-1)) : -1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule